// File: doc/BRIEF.md
# SIMD Element-Reverse Execution Unit

This unit carries out the element-reverse family of vector operations. It takes one 32-bit instruction word and one 128-bit source register value. It cuts the active part of the operand into fixed-size containers and reverses the order of the elements inside each container. Three things come from instruction fields: the element size, the container size and whether the vector is 64 or 128 bits wide. Any combination whose container is not larger than its element is reported as an undefined instruction and is not executed.

The unit sits beside other decoders in an execution pipeline. A word whose fixed opcode bits do not belong to this family is not claimed: the match output stays low and no undefined flag is raised, so another unit can take it. Results, register indices and flags leave the unit registered, one clock after the valid strobe.

Top module: `rev_exec_unit`

## Requirements
- R1: A word is claimed when bit 31 is 0, bits 28:24 are 01110, bits 21:13 are 100000000 and bits 11:10 are 10. `out_match` is then high in the cycle after `in_valid`.
- R2: `out_rd` and `out_rn` carry instruction bits 4:0 and 9:5 of the accepted word, one cycle after `in_valid`.
- R3: The element size is 8 << size bits, where size is bits 23:22. The container size is 64 >> {o0,U} bits, where o0 is bit 12 and U is bit 29. When the container is larger than the element, each container's elements appear in reverse order and the bytes inside each element keep their order. `out_done` is then high for one cycle.
- R4: When the container size is less than or equal to the element size (this covers every size when o0=U=1), `out_undef` goes high, `out_done` stays low and `out_res` is zero.
- R5: Q is bit 30. With Q=1 all 128 bits are processed. With Q=0 only bits 63:0 of the source are used and `out_res[127:64]` is zero.
- R6: A word failing R1 gives `out_match`, `out_undef` and `out_done` all low, with `out_res` zero.
- R7: Without `in_valid`, the three strobes are low in the next cycle and `out_res` keeps its value.
- R8: After reset every output is zero.
- R9: For the halfword variant (o0=1, U=0, size=00), the two bytes of each 16-bit halfword change places. Any other size with that container is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word and operand are present |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector value |
| out_res | output | 128 | Result vector |
| out_rd | output | 5 | Destination register index |
| out_rn | output | 5 | Source register index |
| out_done | output | 1 | Result executed and valid |
| out_undef | output | 1 | Claimed word with a reserved encoding |
| out_match | output | 1 | Word belongs to this unit |

## Verification
In a single cycle the unit must both claim a word and reject it as reserved. A claimed word with an illegal size selection has to raise `out_match` and `out_undef` together, while the permute network next to them is producing bytes that must not leak out. The sweep walks every {Q, U, o0, size} combination with random operands, so legal and reserved forms with identical opcode bits follow each other back to back. For each one the bench checks that done and undef come out as a pair that excludes each other, and that a reserved form gives a zero result. The sweep also flips each fixed opcode bit, to show that leaving a word unclaimed never turns into an undefined flag.

// File: rtl/rev_pkg.sv
package rev_pkg;
    localparam int unsigned VEC_W     = 128;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned MAX_CONT  = 64;
    localparam int unsigned MASK_W    = $clog2(MAX_CONT / LANE_W);
    localparam int unsigned REG_W     = 5;

    typedef struct packed {
        logic              match;
        logic              legal;
        logic              wide;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rn;
        logic [MASK_W-1:0] swap_mask;
    } rev_dec_t;
endpackage

// File: rtl/rev_decode.sv
module rev_decode
    import rev_pkg::*;
(
    input  logic [31:0] insn,
    output rev_dec_t    dec
);
    logic [1:0]        cont_sel;
    logic [MASK_W:0]   cont_log;
    logic [MASK_W:0]   elem_log;
    logic [MASK_W+1:0] span;

    always_comb begin
        dec       = '0;
        dec.match = (insn[31] == 1'b0)
                 && (insn[28:24] == 5'b01110)
                 && (insn[21:13] == 9'b100000000)
                 && (insn[11:10] == 2'b10);
        cont_sel  = {insn[12], insn[29]};
        cont_log  = (MASK_W+1)'(MASK_W) - (MASK_W+1)'(cont_sel);
        elem_log  = (MASK_W+1)'(insn[23:22]);
        dec.legal = cont_log > elem_log;
        dec.wide  = insn[30];
        dec.rd    = insn[4:0];
        dec.rn    = insn[9:5];
        span      = ((MASK_W+2)'(1) << cont_log) - ((MASK_W+2)'(1) << elem_log);
        dec.swap_mask = dec.legal ? span[MASK_W-1:0] : '0;
    end
endmodule

// File: rtl/rev_permute.sv
module rev_permute
    import rev_pkg::*;
#(
    parameter int unsigned DATA_W = VEC_W,
    parameter int unsigned BYTE_W = LANE_W
) (
    input  logic [DATA_W-1:0] src,
    input  logic [MASK_W-1:0] swap_mask,
    input  logic              wide,
    output logic [DATA_W-1:0] res
);
    localparam int unsigned LANES = DATA_W / BYTE_W;
    localparam int unsigned HALF  = LANES / 2;
    localparam int unsigned IDX_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [IDX_W-1:0] pick;
        always_comb pick = IDX_W'(i) ^ IDX_W'(swap_mask);
        if (i < HALF) begin : g_low
            always_comb res[i*BYTE_W +: BYTE_W] = src[pick*BYTE_W +: BYTE_W];
        end else begin : g_high
            always_comb res[i*BYTE_W +: BYTE_W] =
                wide ? src[pick*BYTE_W +: BYTE_W] : '0;
        end
    end
endmodule

// File: rtl/rev_exec_unit.sv
module rev_exec_unit
    import rev_pkg::*;
#(
    parameter int unsigned DATA_W = VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    input  logic [DATA_W-1:0] in_src,
    output logic [DATA_W-1:0] out_res,
    output logic [REG_W-1:0]  out_rd,
    output logic [REG_W-1:0]  out_rn,
    output logic              out_done,
    output logic              out_undef,
    output logic              out_match
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rn;
        logic              done;
        logic              undef;
        logic              match;
    } state_t;

    rev_dec_t          dec;
    logic [DATA_W-1:0] perm;
    state_t            st_d, st_q;

    rev_decode u_decode (
        .insn (in_insn),
        .dec  (dec)
    );

    rev_permute #(.DATA_W(DATA_W), .BYTE_W(LANE_W)) u_permute (
        .src       (in_src),
        .swap_mask (dec.swap_mask),
        .wide      (dec.wide),
        .res       (perm)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.undef = 1'b0;
        st_d.match = 1'b0;
        if (in_valid) begin
            st_d.match = dec.match;
            st_d.rd    = dec.rd;
            st_d.rn    = dec.rn;
            if (dec.match && dec.legal) begin
                st_d.done = 1'b1;
                st_d.res  = perm;
            end else begin
                st_d.undef = dec.match;
                st_d.res   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_res   = st_q.res;
    assign out_rd    = st_q.rd;
    assign out_rn    = st_q.rn;
    assign out_done  = st_q.done;
    assign out_undef = st_q.undef;
    assign out_match = st_q.match;

    // R4
    reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.match && !dec.legal) |=> (out_undef && !out_done && out_res == '0));

    // R6
    foreign_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec.match) |=> (!out_match && !out_undef && !out_done));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_done && !out_undef && !out_match && $stable(out_res)));

    // R5
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_insn[30]) |=> (out_res[DATA_W-1:DATA_W/2] == '0));

    // R2
    index_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_rd == $past(in_insn[4:0]) && out_rn == $past(in_insn[9:5])));
endmodule

// File: tb/rev_exec_unit_bench.sv
module rev_exec_unit_bench;
    localparam int unsigned W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_insn = '0;
    logic [W-1:0] in_src = '0;
    logic [W-1:0] out_res;
    logic [4:0]   out_rd, out_rn;
    logic         out_done, out_undef, out_match;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rev_exec_unit u_rev_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_src(in_src), .out_res(out_res), .out_rd(out_rd), .out_rn(out_rn),
        .out_done(out_done), .out_undef(out_undef), .out_match(out_match)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit q, bit u, bit o0, logic [1:0] sz,
                                       logic [4:0] rn, logic [4:0] rd);
        return {1'b0, q, u, 5'b01110, sz, 9'b100000000, o0, 2'b10, rn, rd};
    endfunction

    function automatic logic [W-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic apply(logic [31:0] insn, logic [W-1:0] src);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = insn;
        in_src   = src;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic judge(logic [31:0] insn, logic [W-1:0] src);
        bit m, q, legal;
        int eb, cb, nb, ne;
        logic [W-1:0] exp;
        string tag;
        m = (insn[31] == 1'b0) && (insn[28:24] == 5'b01110)
            && (insn[21:13] == 9'b100000000) && (insn[11:10] == 2'b10);
        q  = insn[30];
        eb = 1 << insn[23:22];
        cb = 8 >> {insn[12], insn[29]};
        legal = cb > eb;
        nb = q ? 16 : 8;
        exp = '0;
        if (m && legal) begin
            ne = cb / eb;
            for (int c = 0; c < nb / cb; c++)
                for (int k = 0; k < ne; k++)
                    for (int j = 0; j < eb; j++)
                        exp[(c*cb + (ne-1-k)*eb + j)*8 +: 8] = src[(c*cb + k*eb + j)*8 +: 8];
        end
        if (!m) tag = "R6";
        else if (!legal) tag = (insn[12] && !insn[29]) ? "R9/R4" : "R4";
        else if (!q) tag = "R5";
        else if (insn[12] && !insn[29]) tag = "R9";
        else tag = "R3";
        chk({tag, " result"}, out_res, exp);
        chk({tag, " done/undef"}, W'({out_done, out_undef}),
            W'({m && legal, m && !legal}));
        chk("R1 match", W'(out_match), W'(m));
        chk("R2 indices", W'({out_rd, out_rn}), W'({insn[4:0], insn[9:5]}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [W-1:0] s, held;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset", W'({out_res, out_rd, out_rn, out_done, out_undef, out_match}), '0);
        rst_n = 1'b1;

        // R9 fixed pattern: bytes swap inside each halfword
        s = 128'h0f0e0d0c0b0a09080706050403020100;
        w = mk(1'b1, 1'b0, 1'b1, 2'b00, 5'd7, 5'd19);
        apply(w, s);
        chk("R9 halfword", out_res, 128'h0e0f0c0d0a0b08090607040502030001);
        judge(w, s);

        // R3 R4 R5 R9 full sweep over arrangement fields
        for (int q = 0; q < 2; q++)
            for (int ou = 0; ou < 4; ou++)
                for (int sz = 0; sz < 4; sz++)
                    for (int r = 0; r < 4; r++) begin
                        w = mk(q[0], ou[0], ou[1], sz[1:0], 5'($urandom), 5'($urandom));
                        s = rnd128();
                        apply(w, s);
                        judge(w, s);
                    end

        // R6 each fixed opcode bit flipped
        for (int b = 0; b < 32; b++) begin
            if (b == 31 || (b >= 24 && b <= 28) || (b >= 13 && b <= 21) || b == 10 || b == 11) begin
                w = mk(1'b1, 1'b0, 1'b1, 2'b00, 5'd3, 5'd4) ^ (32'd1 << b);
                s = rnd128();
                apply(w, s);
                judge(w, s);
            end
        end

        // R7 idle cycles hold the result and drop the strobes
        w = mk(1'b1, 1'b0, 1'b0, 2'b00, 5'd1, 5'd2);
        s = rnd128();
        apply(w, s);
        judge(w, s);
        held = out_res;
        in_src = rnd128();
        in_insn = mk(1'b1, 1'b0, 1'b1, 2'b00, 5'd9, 5'd9);
        @(posedge clk);
        @(negedge clk);
        chk("R7 hold", out_res, held);
        chk("R7 strobes", W'({out_done, out_undef, out_match}), '0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule